// File: doc/BRIEF.md
# Strobed Parallel Bus Peripheral with Read Counter

This block is a target on an asynchronous, host-driven parallel bus with a 6-bit address, a 16-bit data path and two active-low strobes, one for reads and one for writes. A read returns a free-running sequence number: the first read after reset returns zero, and each completed read advances the number by one. A write stores the data word in one of a small bank of registers. The low address bits pick the register. The register bank is brought out to the rest of the chip as a flat vector.

The strobes are not tied to the local clock. The output enable for the data pins is formed directly from the raw strobes, so valid data reaches the pins well inside the short strobe window. The counter and the register bank sit in the local clock domain. They use copies of the strobes that pass through a two-flop synchronizer, and they act on the synchronized rising edge, after the host has finished with the bus. The pad-level tri-state buffer lives at chip level. It is driven by `data_o` and `data_oe`.

Top module: `pbus_periph`

## Requirements
- R1: After reset the read value `data_o` is 0, `data_oe` is low and every register slot in `reg_q` is 0.
- R2: `data_oe` is high exactly when `rd_n` is low and `wr_n` is high, at the same moment with no clock involved, and low at every other time.
- R3: During a read, `data_o` carries the current counter value, and the first read after reset returns 0.
- R4: Each read ends when `rd_n` rises with `wr_n` high. Each such read raises the counter by exactly 1, and the new value shows on `data_o` within 4 clock cycles of the rising edge.
- R5: `data_o` does not change while `rd_n` is held low.
- R6: A write ends when `wr_n` rises with `rd_n` high. It stores `data_i` in slot `bus_addr[1:0]`, which occupies bits `[16*slot+15:16*slot]` of `reg_q`, within 5 clock cycles. Address bits 5..2 are ignored, and the other slots keep their contents.
- R7: While both strobes are low together, `data_oe` stays low. When both then rise, no register is written and the counter does not advance.
- R8: A write leaves the counter unchanged, and a read leaves every register slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Bus address, bit 5 most significant |
| rd_n | input | 1 | Active-low read strobe from the host |
| wr_n | input | 1 | Active-low write strobe from the host |
| data_i | input | 16 | Data from the pins during a write |
| data_o | output | 16 | Data to the pins during a read (counter value) |
| data_oe | output | 1 | Pin driver enable; the pins float when low |
| reg_q | output | 64 | Register bank, slot n in bits 16n+15..16n |

## Verification
The clocked properties assume that every strobe stays low for at least three clock cycles and stays high for several cycles between accesses. They also assume that address and data stay steady for the whole time a write strobe is low. Under those conditions the synchronizer sees every edge once, and a snapshot taken just after the falling edge holds the final word. The stimulus meets these conditions: each strobe is held low for three cycles and released for at least five. Address and write data change only while the strobes are idle. Overlapping strobes fall together and rise one cycle apart, so the overlap is seen as a single event.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 6;
  localparam int SLOTS  = 4;
  localparam int SYNC_N = 2;
  localparam int RD_BIT = 1;
  localparam int WR_BIT = 0;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int N = pbus_pkg::SYNC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] s1_o,
  output logic [N-1:0] s2_o,
  output logic [N-1:0] s3_o
);
  logic [N-1:0] st1, st2, st3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '1;
      st2 <= '1;
      st3 <= '1;
    end else begin
      st1 <= async_i;
      st2 <= st1;
      st3 <= st2;
    end
  end

  assign s1_o = st1;
  assign s2_o = st2;
  assign s3_o = st3;
endmodule

// File: rtl/pbus_count.sv
module pbus_count #(
  parameter int CW = pbus_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump_i,
  output logic [CW-1:0] count_o
);
  function automatic logic [CW-1:0] advance(input logic [CW-1:0] v);
    return v + {{(CW-1){1'b0}}, 1'b1};
  endfunction

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (bump_i) cnt <= advance(cnt);
  end

  assign count_o = cnt;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bump_i |=> count_o == advance($past(count_o)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bump_i |=> $stable(count_o));
endmodule

// File: rtl/pbus_regs.sv
module pbus_regs #(
  parameter int DW = pbus_pkg::WORD_W,
  parameter int NREG = pbus_pkg::SLOTS,
  localparam int IW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IW-1:0]      slot_i,
  input  logic [DW-1:0]      data_i,
  input  logic               wr_s1_i,
  input  logic               wr_s2_i,
  input  logic               commit_i,
  output logic [NREG*DW-1:0] reg_q
);
  function automatic logic slot_hit(input logic [IW-1:0] sel, input int idx);
    return sel == idx[IW-1:0];
  endfunction

  logic [DW-1:0] smp_data, hold_data;
  logic [IW-1:0] smp_slot, hold_slot;
  logic          first_low;

  // Sample pins at the same edge the strobe enters stage 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_data <= '0;
      smp_slot <= '0;
    end else begin
      smp_data <= data_i;
      smp_slot <= slot_i;
    end
  end

  assign first_low = !wr_s1_i && wr_s2_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_slot <= '0;
    end else if (first_low) begin
      hold_data <= smp_data;
      hold_slot <= smp_slot;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [DW-1:0] word;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                word <= '0;
      else if (commit_i && slot_hit(hold_slot, g)) word <= hold_data;
    end
    assign reg_q[g*DW +: DW] = word;
  end

  assert_regs_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(reg_q));
endmodule

// File: rtl/pbus_periph.sv
module pbus_periph #(
  parameter int DW = pbus_pkg::WORD_W,
  parameter int AW = pbus_pkg::ADDR_W,
  parameter int NREG = pbus_pkg::SLOTS,
  localparam int IW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [DW-1:0]      data_i,
  output logic [DW-1:0]      data_o,
  output logic               data_oe,
  output logic [NREG*DW-1:0] reg_q
);
  import pbus_pkg::RD_BIT;
  import pbus_pkg::WR_BIT;

  logic [1:0] s1, s2, s3;
  logic rd_rise, wr_rise, both_low, both_idle;
  logic clash;
  logic rd_done, wr_commit;
  logic [DW-1:0] count;

  pbus_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({rd_n, wr_n}),
    .s1_o(s1), .s2_o(s2), .s3_o(s3)
  );

  // Named events for the properties.
  assign rd_rise   = s2[RD_BIT] && !s3[RD_BIT];
  assign wr_rise   = s2[WR_BIT] && !s3[WR_BIT];
  assign both_low  = !s1[RD_BIT] && !s1[WR_BIT];
  assign both_idle = (&s2) && (&s3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clash <= 1'b0;
    else if (both_low)  clash <= 1'b1;
    else if (both_idle) clash <= 1'b0;
  end

  assign rd_done   = rd_rise && !clash;
  assign wr_commit = wr_rise && !clash;

  pbus_count #(.CW(DW)) u_count (
    .clk(clk), .rst_n(rst_n), .bump_i(rd_done), .count_o(count)
  );

  pbus_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .slot_i(bus_addr[IW-1:0]), .data_i(data_i),
    .wr_s1_i(s1[WR_BIT]), .wr_s2_i(s2[WR_BIT]), .commit_i(wr_commit),
    .reg_q(reg_q)
  );

  // Drive enable straight from the strobes: no clock in the path.
  assign data_oe = !rd_n && wr_n;
  assign data_o  = count;

  assert_out_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(data_o));
  assert_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clash && wr_rise) |=> $stable(reg_q));
endmodule

// File: tb/sim_pbus_periph.sv
module sim_pbus_periph;
  localparam int DW = 16;
  localparam int NREG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_addr = 6'h3f;
  logic rd_n = 1'b1;
  logic wr_n = 1'b1;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic data_oe;
  logic [NREG*DW-1:0] reg_q;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] model_cnt = '0;
  logic [DW-1:0] model_reg [NREG];
  logic [DW-1:0] exp_q [$];

  always #5 clk = ~clk;

  pbus_periph u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .reg_q(reg_q)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, reg_q[i*DW +: DW], model_reg[i]);
  endtask

  // Monitor: score each completed read at the strobe's rising edge.
  always @(posedge rd_n) begin
    if (wr_n && exp_q.size() > 0) chk("R3/R4 read value", data_o, exp_q.pop_front());
  end

  task automatic do_read(input logic [5:0] a);
    logic [DW-1:0] first;
    @(negedge clk);
    bus_addr = a;
    rd_n = 1'b0;
    exp_q.push_back(model_cnt);
    model_cnt = model_cnt + 1'b1;
    @(negedge clk);
    chk("R2 oe in read", {15'd0, data_oe}, 16'd1);
    first = data_o;
    repeat (2) @(negedge clk);
    chk("R5 stable in read", data_o, first);
    rd_n = 1'b1;
    #1 chk("R2 oe after read", {15'd0, data_oe}, 16'd0);
    repeat (4) @(negedge clk);
    chk("R4 advanced", data_o, model_cnt);
    chk_regs("R8 read keeps regs");
    bus_addr = 6'h3f;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    data_i = d;
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 oe in write", {15'd0, data_oe}, 16'd0);
    wr_n = 1'b1;
    @(negedge clk);
    data_i = ~d;
    bus_addr = ~a;
    repeat (5) @(negedge clk);
    model_reg[a[1:0]] = d;
    chk_regs("R6 write");
    chk("R8 write keeps count", data_o, model_cnt);
    bus_addr = 6'h3f;
    data_i = '0;
  endtask

  task automatic do_clash(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    data_i = d;
    rd_n = 1'b0;
    wr_n = 1'b0;
    @(negedge clk);
    chk("R7 oe in overlap", {15'd0, data_oe}, 16'd0);
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_regs("R7 overlap no write");
    chk("R7 overlap no count", data_o, model_cnt);
    bus_addr = 6'h3f;
    data_i = '0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog R1: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", data_o, 16'd0);
    chk("R1 reset oe", {15'd0, data_oe}, 16'd0);
    chk_regs("R1 reset regs");

    do_read(6'h00);
    do_read(6'h11);
    do_read(6'h3f);
    do_write(6'h00, 16'hA5C3);
    do_write(6'h25, 16'h1234);
    do_write(6'h3e, 16'hFFFF);
    do_write(6'h0b, 16'h0001);
    do_read(6'h02);
    do_clash(6'h01, 16'hDEAD);
    do_read(6'h01);
    do_write(6'h01, 16'h8000);
    do_clash(6'h02, 16'hBEEF);
    do_write(6'h06, 16'h00F0);
    for (int k = 0; k < 5; k++) do_read(6'(k));

    // No read in progress: enable stays low with only address moving.
    bus_addr = 6'h00;
    #3 chk("R2 oe idle", {15'd0, data_oe}, 16'd0);
    repeat (2) @(negedge clk);
    chk("R3 queue drained", 16'(exp_q.size()), 16'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule